// File: doc/BRIEF.md
# Multiprocessor-Format Serial Transceiver

This block is a byte-wide asynchronous serial transmitter and receiver. A small register bus gives access to control, transmit data, status and receive data. A mode input selects a multiprocessor frame format. In that format each character carries one extra bit after its data bits, which marks the character as an address or as data. On the transmit side that bit is taken from a control bit. On the receive side it is captured into a status bit that software can only read.

Serial timing comes from an external baud tick that runs at sixteen times the bit rate. The transmitter starts a character only on a tick and holds each bit for sixteen ticks. The receiver takes a majority-free centre sample, eight ticks into the start bit and then every sixteen ticks. A transmit-end flag tells software when the line has gone quiet with nothing left to send. It is cleared only by a read-then-write handshake on the transmit-empty flag, and several conditions force it high.

Top module: `mpuart_core`

## Requirements
- R1: After reset the status register (address 2) reads tdre (bit 0) = 1, tend (bit 1) = 1, mpb (bit 2) = 0, rdrf (bit 3) = 0 and ferr (bit 4) = 0. The control register (address 0: tx_en bit 0, rx_en bit 1, mpbt bit 2) reads 0, and the serial output idles high.
- R2: With the multiprocessor format selected, a transmitted character is a low start bit, then 8 data bits LSB first, then the multiprocessor bit equal to mpbt as sampled when the character was loaded, then a high stop bit. Each bit lasts 16 baud ticks.
- R3: With the format deselected, the multiprocessor slot is absent and the stop bit follows the last data bit. mpbt then has no effect on the line.
- R4: Writing 0 to tdre at address 2 clears tdre and tend only if the most recent access to address 2 before it was a read that returned tdre = 1. Any other write to address 2 leaves tdre and tend unchanged.
- R5: While tx_en is 1, tdre is 0 and the shifter is idle, the held byte (written at address 1) loads on the next baud tick. The start bit begins on the line, and tdre returns to 1.
- R6: At the end of a stop bit, tend becomes 1 if tdre is 1. If tdre is 0, the next character starts with no idle gap and tend stays 0.
- R7: Clearing tx_en forces tend to 1 and returns the line high, including in the middle of a character. A high standby input also forces tend to 1.
- R8: With rx_en = 1 and the format selected, a received character sets rdrf, presents its data at address 3 and stores its multiprocessor bit in mpb. Writes to address 2 never change mpb.
- R9: While rx_en is 0, no character is received, rdrf stays 0 and mpb keeps its value.
- R10: A start bit that is no longer low 8 ticks after the falling edge is discarded, and the receiver waits for the next falling edge.
- R11: A stop bit sampled as 0 sets ferr together with rdrf. A read of address 3 clears both rdrf and ferr.
- R12: A character received with the format deselected leaves mpb at its previous value and still delivers its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Low-power state indicator; forces tend high |
| baud_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| mp_mode_i | input | 1 | Selects the multiprocessor frame format |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed register |
| rxd_i | input | 1 | Serial input |
| txd_o | output | 1 | Serial output |

## Verification
The bound checker watches the transmit-side rules on every cycle. These are the forcing of tend by tx_en and standby, the line returning high when transmission is disabled, loads happening only on a tick with pending data, the start bit following every load, tend rising at a stop-bit end with nothing pending, and tend falling only through the handshake. It also checks that mpb changes only on a completed frame and never while reception is off. The scenarios alone can show the frame contents bit by bit, the omission of the multiprocessor slot, back-to-back characters, the refusal of an unarmed clear, and the receiver's glitch rejection, framing error and data delivery.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TXD  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_RXD  = 2'd3;

  localparam int CTL_TXEN = 0;
  localparam int CTL_RXEN = 1;
  localparam int CTL_MPBT = 2;

  localparam int ST_TDRE = 0;
  localparam int ST_TEND = 1;
  localparam int ST_MPB  = 2;
  localparam int ST_RDRF = 3;
  localparam int ST_FERR = 4;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;
endpackage

// File: rtl/mpuart_tx.sv
module mpuart_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              tick_i,
  input  logic              mp_mode_i,
  input  logic              mp_bit_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              data_valid_i,
  output logic              load_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int SUB_W   = $clog2(OVS);
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  // Line image of one character, bit 0 goes out first.
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [DATA_W-1:0] d,
                                                   input logic mp_en, input logic mp_b);
    pack_frame = mp_en ? {1'b1, mp_b, d, 1'b0} : {2'b11, d, 1'b0};
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(input logic mp_en);
    frame_len = mp_en ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
  endfunction

  logic               busy_q;
  logic [SUB_W-1:0]   sub_q;
  logic [CNT_W-1:0]   left_q;
  logic [FRAME_W-1:0] shreg_q;

  logic bit_end, last_bit;
  assign bit_end  = busy_q && tick_i && (sub_q == SUB_W'(OVS - 1));
  assign last_bit = bit_end && (left_q == CNT_W'(1));
  assign done_o   = last_bit;
  assign load_o   = enable_i && tick_i && data_valid_i && (!busy_q || last_bit);
  assign busy_o   = busy_q;
  assign txd_o    = shreg_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sub_q   <= '0;
      left_q  <= '0;
      shreg_q <= '1;
    end else if (!enable_i) begin
      busy_q  <= 1'b0;
      sub_q   <= '0;
      left_q  <= '0;
      shreg_q <= '1;
    end else if (load_o) begin
      busy_q  <= 1'b1;
      sub_q   <= '0;
      left_q  <= frame_len(mp_mode_i);
      shreg_q <= pack_frame(data_i, mp_mode_i, mp_bit_i);
    end else if (last_bit) begin
      busy_q  <= 1'b0;
      sub_q   <= '0;
      left_q  <= '0;
      shreg_q <= '1;
    end else if (bit_end) begin
      sub_q   <= '0;
      left_q  <= left_q - CNT_W'(1);
      shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
    end else if (busy_q && tick_i) begin
      sub_q   <= sub_q + SUB_W'(1);
    end
  end
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
  import mpuart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              tick_i,
  input  logic              mp_mode_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              mp_o,
  output logic              mp_valid_o,
  output logic              stop_ok_o
);
  localparam int SUB_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W + 3);
  localparam int HALF  = OVS / 2;

  // Bits that follow the start bit, stop bit included.
  function automatic logic [IDX_W-1:0] bits_after_start(input logic mp_en);
    bits_after_start = IDX_W'(DATA_W + 1) + IDX_W'(mp_en);
  endfunction

  logic [1:0]       sync_q;
  logic             rx_s;
  rx_state_e        state_q;
  logic [SUB_W-1:0] sub_q;
  logic [IDX_W-1:0] idx_q;
  logic [DATA_W:0]  bits_q;
  logic             mp_q;

  assign rx_s = sync_q[1];

  logic start_mid, bit_mid, last_bit;
  assign start_mid = (state_q == RX_START) && tick_i && (sub_q == SUB_W'(HALF - 1));
  assign bit_mid   = (state_q == RX_BITS) && tick_i && (sub_q == SUB_W'(OVS - 1));
  assign last_bit  = bit_mid && (idx_q == bits_after_start(mp_q) - IDX_W'(1));

  assign done_o     = last_bit && enable_i;
  assign data_o     = bits_q[DATA_W-1:0];
  assign mp_o       = bits_q[DATA_W];
  assign mp_valid_o = mp_q;
  assign stop_ok_o  = rx_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      bits_q  <= '0;
      mp_q    <= 1'b0;
    end else if (!enable_i) begin
      state_q <= RX_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        RX_IDLE: if (tick_i && !rx_s) begin
          state_q <= RX_START;
          sub_q   <= '0;
          mp_q    <= mp_mode_i;
        end
        RX_START: if (start_mid) begin
          sub_q   <= '0;
          idx_q   <= '0;
          state_q <= rx_s ? RX_IDLE : RX_BITS;
        end else if (tick_i) begin
          sub_q <= sub_q + SUB_W'(1);
        end
        RX_BITS: if (bit_mid) begin
          if (idx_q <= IDX_W'(DATA_W)) bits_q[idx_q] <= rx_s;
          idx_q <= idx_q + IDX_W'(1);
          sub_q <= '0;
          if (last_bit) state_q <= RX_IDLE;
        end else if (tick_i) begin
          sub_q <= sub_q + SUB_W'(1);
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mpuart_status.sv
module mpuart_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              standby_i,
  input  logic              tx_en_i,
  input  logic              stat_rd_i,
  input  logic              stat_wr_i,
  input  logic              tdre_wbit_i,
  input  logic              tx_load_i,
  input  logic              tx_done_i,
  input  logic              rx_done_i,
  input  logic              rx_mp_valid_i,
  input  logic              rx_mp_i,
  input  logic              rx_stop_ok_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rxd_rd_i,
  output logic              tdre_o,
  output logic              tend_o,
  output logic              mpb_o,
  output logic              rdrf_o,
  output logic              ferr_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tdre_clr_o
);
  logic armed_q;

  assign tdre_clr_o = stat_wr_i && !tdre_wbit_i && armed_q && tdre_o;

  // Arm on a status read that saw tdre high; any status write disarms.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          armed_q <= 1'b0;
    else if (stat_wr_i)   armed_q <= 1'b0;
    else if (stat_rd_i && tdre_o) armed_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tdre_o <= 1'b1;
    else if (tdre_clr_o) tdre_o <= 1'b0;
    else if (tx_load_i)  tdre_o <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    tend_o <= 1'b1;
    else if (standby_i || !tx_en_i) tend_o <= 1'b1;
    else if (tdre_clr_o)            tend_o <= 1'b0;
    else if (tx_done_i && tdre_o)   tend_o <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         mpb_o <= 1'b0;
    else if (rx_done_i && rx_mp_valid_i) mpb_o <= rx_mp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdrf_o    <= 1'b0;
      ferr_o    <= 1'b0;
      rx_data_o <= '0;
    end else if (rx_done_i) begin
      rdrf_o    <= 1'b1;
      ferr_o    <= !rx_stop_ok_i;
      rx_data_o <= rx_data_i;
    end else if (rxd_rd_i) begin
      rdrf_o <= 1'b0;
      ferr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mpuart_core.sv
module mpuart_core
  import mpuart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              standby_i,
  input  logic              baud_tick_i,
  input  logic              mp_mode_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              rxd_i,
  output logic              txd_o
);
  logic tx_en_q, rx_en_q, mpbt_q;
  logic [DATA_W-1:0] tx_hold_q;

  // Named internal events, visible to the bound checker.
  logic wr_ctrl, wr_txd, stat_wr, stat_rd, rxd_rd;
  logic tx_load, tx_done, tx_busy, tdre_clr;
  logic rx_done, rx_mp, rx_mp_valid, rx_stop_ok;
  logic [DATA_W-1:0] rx_shift_data, rx_data;
  logic tdre, tend, mpb, rdrf, ferr;

  assign wr_ctrl = bus_sel_i &&  bus_wr_i && (bus_addr_i == ADDR_CTRL);
  assign wr_txd  = bus_sel_i &&  bus_wr_i && (bus_addr_i == ADDR_TXD);
  assign stat_wr = bus_sel_i &&  bus_wr_i && (bus_addr_i == ADDR_STAT);
  assign stat_rd = bus_sel_i && !bus_wr_i && (bus_addr_i == ADDR_STAT);
  assign rxd_rd  = bus_sel_i && !bus_wr_i && (bus_addr_i == ADDR_RXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      mpbt_q  <= 1'b0;
    end else if (wr_ctrl) begin
      tx_en_q <= bus_wdata_i[CTL_TXEN];
      rx_en_q <= bus_wdata_i[CTL_RXEN];
      mpbt_q  <= bus_wdata_i[CTL_MPBT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tx_hold_q <= '0;
    else if (wr_txd) tx_hold_q <= bus_wdata_i;
  end

  mpuart_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (tx_en_q),
    .tick_i       (baud_tick_i),
    .mp_mode_i    (mp_mode_i),
    .mp_bit_i     (mpbt_q),
    .data_i       (tx_hold_q),
    .data_valid_i (!tdre),
    .load_o       (tx_load),
    .done_o       (tx_done),
    .busy_o       (tx_busy),
    .txd_o        (txd_o)
  );

  mpuart_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (rx_en_q),
    .tick_i     (baud_tick_i),
    .mp_mode_i  (mp_mode_i),
    .rxd_i      (rxd_i),
    .done_o     (rx_done),
    .data_o     (rx_shift_data),
    .mp_o       (rx_mp),
    .mp_valid_o (rx_mp_valid),
    .stop_ok_o  (rx_stop_ok)
  );

  mpuart_status #(.DATA_W(DATA_W)) u_stat (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .standby_i     (standby_i),
    .tx_en_i       (tx_en_q),
    .stat_rd_i     (stat_rd),
    .stat_wr_i     (stat_wr),
    .tdre_wbit_i   (bus_wdata_i[ST_TDRE]),
    .tx_load_i     (tx_load),
    .tx_done_i     (tx_done),
    .rx_done_i     (rx_done),
    .rx_mp_valid_i (rx_mp_valid),
    .rx_mp_i       (rx_mp),
    .rx_stop_ok_i  (rx_stop_ok),
    .rx_data_i     (rx_shift_data),
    .rxd_rd_i      (rxd_rd),
    .tdre_o        (tdre),
    .tend_o        (tend),
    .mpb_o         (mpb),
    .rdrf_o        (rdrf),
    .ferr_o        (ferr),
    .rx_data_o     (rx_data),
    .tdre_clr_o    (tdre_clr)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADDR_CTRL: begin
        bus_rdata_o[CTL_TXEN] = tx_en_q;
        bus_rdata_o[CTL_RXEN] = rx_en_q;
        bus_rdata_o[CTL_MPBT] = mpbt_q;
      end
      ADDR_TXD: bus_rdata_o = tx_hold_q;
      ADDR_STAT: begin
        bus_rdata_o[ST_TDRE] = tdre;
        bus_rdata_o[ST_TEND] = tend;
        bus_rdata_o[ST_MPB]  = mpb;
        bus_rdata_o[ST_RDRF] = rdrf;
        bus_rdata_o[ST_FERR] = ferr;
      end
      default: bus_rdata_o = rx_data;
    endcase
  end
endmodule

// File: rtl/mpuart_checker.sv
module mpuart_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic standby,
  input logic tick,
  input logic tx_en,
  input logic rx_en,
  input logic txd,
  input logic tx_load,
  input logic tx_done,
  input logic tdre,
  input logic tdre_clr,
  input logic tend,
  input logic mpb,
  input logic rx_done
);
  assert_tend_forced_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en || standby) |=> tend);

  assert_line_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en |=> txd);

  assert_start_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load |=> !txd);

  assert_load_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load |-> (tick && tx_en && !tdre));

  assert_load_refills_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load |=> tdre);

  assert_tend_at_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done && tdre && !tdre_clr) |=> tend);

  assert_tend_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tend) |-> $past(tdre_clr));

  assert_mpb_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rx_en) |-> $stable(mpb));

  assert_mpb_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mpb) |-> $past(rx_done));
endmodule

bind mpuart_core mpuart_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .standby  (standby_i),
  .tick     (baud_tick_i),
  .tx_en    (tx_en_q),
  .rx_en    (rx_en_q),
  .txd      (txd_o),
  .tx_load  (tx_load),
  .tx_done  (tx_done),
  .tdre     (tdre),
  .tdre_clr (tdre_clr),
  .tend     (tend),
  .mpb      (mpb),
  .rx_done  (rx_done)
);

// File: tb/mpuart_core_tb_top.sv
module mpuart_core_tb_top;
  localparam int OVS = 16;
  localparam logic [1:0] A_CTRL = 2'd0, A_TXD = 2'd1, A_STAT = 2'd2, A_RXD = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby = 1'b0;
  logic tick = 1'b0;
  logic mp_mode = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic rxd = 1'b1;
  logic txd;

  int n_checks = 0;
  int n_fail = 0;
  int frames_seen = 0;
  bit abort_flag = 1'b0;
  bit finished = 1'b0;

  typedef struct packed { logic [7:0] d; logic mp_en; logic mp; } exp_t;
  exp_t exp_q[$];

  mpuart_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .baud_tick_i(tick),
    .mp_mode_i(mp_mode), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .rxd_i(rxd), .txd_o(txd)
  );

  always #10 clk = ~clk;

  // Tick: high on every second cycle, changed at negedge.
  always @(negedge clk) tick <= ~tick;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!tick);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  // Driver: waits for an empty holding register, then load + handshake.
  task automatic send(input logic [7:0] d, input logic mp_en, input logic mpbt);
    logic [7:0] s;
    exp_t e;
    do bus_read(A_STAT, s); while (!s[0]);
    e.d = d; e.mp_en = mp_en; e.mp = mpbt;
    exp_q.push_back(e);
    bus_write(A_TXD, d);
    bus_read(A_STAT, s);
    bus_write(A_STAT, 8'h00);
  endtask

  task automatic wait_frames(input int n);
    while (frames_seen < n) @(posedge clk);
  endtask

  task automatic drive_rx(input logic [7:0] d, input logic mp_en, input logic mp, input logic stop);
    rxd = 1'b0; wait_ticks(OVS);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; wait_ticks(OVS); end
    if (mp_en) begin rxd = mp; wait_ticks(OVS); end
    rxd = stop; wait_ticks(OVS);
    rxd = 1'b1; wait_ticks(4);
  endtask

  // Monitor: decodes the serial output and compares with the queue.
  always begin
    @(negedge txd);
    if (!abort_flag) begin
      exp_t e;
      logic [7:0] got;
      logic mpv, stp, st;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected frame", 0, 1);
      end else begin
        e = exp_q.pop_front();
        wait_ticks(OVS/2); #1 st = txd;
        for (int i = 0; i < 8; i++) begin wait_ticks(OVS); #1 got[i] = txd; end
        mpv = 1'b0;
        if (e.mp_en) begin wait_ticks(OVS); #1 mpv = txd; end
        wait_ticks(OVS); #1 stp = txd;
        chk(st == 1'b0, "R2 start bit", st, 0);
        chk(got == e.d, "R2 data bits", got, e.d);
        if (e.mp_en) chk(mpv == e.mp, "R2 multiprocessor bit", mpv, e.mp);
        chk(stp == 1'b1, e.mp_en ? "R2 stop bit" : "R3 stop follows data", stp, 1);
        frames_seen++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    #1 chk(txd == 1'b1, "R1 line idle", txd, 1);
    bus_read(A_STAT, s);
    chk(s[4:0] == 5'b00011, "R1 status after reset", s, 8'h03);
    bus_read(A_CTRL, s);
    chk(s[2:0] == 3'b000, "R1 control after reset", s, 0);

    // R4 unarmed clear: read arms, write with bit0=1 disarms, write 0 is ignored
    bus_write(A_CTRL, 8'h03);
    bus_read(A_STAT, s);
    bus_write(A_STAT, 8'h01);
    bus_write(A_STAT, 8'h00);
    bus_read(A_STAT, s);
    chk(s[1:0] == 2'b11, "R4 unarmed write ignored", s[1:0], 2'b11);

    // R2/R5 multiprocessor frame with mpbt=1
    mp_mode = 1'b1;
    bus_write(A_CTRL, 8'h07);
    send(8'hA5, 1'b1, 1'b1);
    bus_read(A_STAT, s);
    chk(s[1] == 1'b0, "R4 handshake clears tend", s[1], 0);
    chk(s[0] == 1'b1, "R5 tdre refilled after load", s[0], 1);
    wait_frames(1);
    wait_ticks(OVS);
    bus_read(A_STAT, s);
    chk(s[1:0] == 2'b11, "R6 tend after last stop bit", s[1:0], 2'b11);

    // R2 mpbt=0
    bus_write(A_CTRL, 8'h03);
    send(8'h3C, 1'b1, 1'b0);
    wait_frames(2);

    // R3 format off, mpbt=1 has no slot
    mp_mode = 1'b0;
    bus_write(A_CTRL, 8'h07);
    send(8'hC3, 1'b0, 1'b1);
    wait_frames(3);

    // R6 back-to-back
    mp_mode = 1'b1;
    send(8'h11, 1'b1, 1'b1);
    send(8'h22, 1'b1, 1'b1);
    wait_frames(4);
    wait_ticks(OVS);
    bus_read(A_STAT, s);
    chk(s[1] == 1'b0, "R6 tend low between chained frames", s[1], 0);
    wait_frames(5);
    wait_ticks(OVS);

    // R7 abort by clearing tx_en
    abort_flag = 1'b1;
    bus_write(A_TXD, 8'h5A);
    bus_read(A_STAT, s);
    bus_write(A_STAT, 8'h00);
    repeat (40) @(posedge clk);
    bus_write(A_CTRL, 8'h06);
    bus_read(A_STAT, s);
    chk(s[1] == 1'b1, "R7 tx_en clear forces tend", s[1], 1);
    #1 chk(txd == 1'b1, "R7 line high after disable", txd, 1);
    wait_ticks(OVS);
    abort_flag = 1'b0;
    bus_write(A_CTRL, 8'h07);

    // R7 standby forces tend mid-frame
    send(8'h96, 1'b1, 1'b1);
    repeat (60) @(posedge clk);
    @(negedge clk) standby = 1'b1;
    @(negedge clk) standby = 1'b0;
    bus_read(A_STAT, s);
    chk(s[1] == 1'b1, "R7 standby forces tend", s[1], 1);
    wait_frames(6);

    // R8 receive with mp=1
    bus_write(A_CTRL, 8'h03);
    drive_rx(8'h5A, 1'b1, 1'b1, 1'b1);
    bus_read(A_STAT, s);
    chk(s[4:2] == 3'b011, "R8 rdrf and mpb set", s[4:2], 3'b011);
    bus_read(A_RXD, s);
    chk(s == 8'h5A, "R8 received data", s, 8'h5A);
    bus_read(A_STAT, s);
    chk(s[3] == 1'b0, "R11 rdrf cleared by data read", s[3], 0);

    // R8 mp=0 then write attempt to mpb
    drive_rx(8'h81, 1'b1, 1'b0, 1'b1);
    bus_read(A_RXD, s);
    bus_write(A_STAT, 8'h05);
    bus_read(A_STAT, s);
    chk(s[2] == 1'b0, "R8 mpb read-only and captured 0", s[2], 0);

    // R12 format off keeps mpb
    drive_rx(8'h33, 1'b1, 1'b1, 1'b1);
    bus_read(A_RXD, s);
    mp_mode = 1'b0;
    drive_rx(8'h7E, 1'b0, 1'b0, 1'b1);
    bus_read(A_STAT, s);
    chk(s[3:2] == 2'b11, "R12 mpb kept, rdrf set", s[3:2], 2'b11);
    bus_read(A_RXD, s);
    chk(s == 8'h7E, "R12 data without mp slot", s, 8'h7E);

    // R9 receiver off
    mp_mode = 1'b1;
    bus_write(A_CTRL, 8'h01);
    drive_rx(8'h44, 1'b1, 1'b0, 1'b1);
    bus_read(A_STAT, s);
    chk(s[3:2] == 2'b01, "R9 no receive, mpb held", s[3:2], 2'b01);

    // R11 framing error
    bus_write(A_CTRL, 8'h03);
    drive_rx(8'hE7, 1'b1, 1'b1, 1'b0);
    wait_ticks(OVS);
    bus_read(A_STAT, s);
    chk(s[4:3] == 2'b11, "R11 ferr with rdrf", s[4:3], 2'b11);
    bus_read(A_RXD, s);
    bus_read(A_STAT, s);
    chk(s[4:3] == 2'b00, "R11 data read clears ferr", s[4:3], 0);

    // R10 short start pulse rejected, then a good frame
    rxd = 1'b0; wait_ticks(3);
    rxd = 1'b1; wait_ticks(40);
    bus_read(A_STAT, s);
    chk(s[3] == 1'b0, "R10 glitch rejected", s[3], 0);
    drive_rx(8'h69, 1'b1, 1'b0, 1'b1);
    bus_read(A_RXD, s);
    chk(s == 8'h69, "R10 receiver recovers", s, 8'h69);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule